// File: doc/BRIEF.md
# Interrupt Distributor Configuration Bank

This block holds the configuration state of a set of interrupt lines, grouped in words of 32. For each line it keeps an enable bit, a pending bit, a group bit, a group-modifier bit, an 8-bit priority and an 8-bit CPU target mask. Software reaches this state over a simple 32-bit register bus with byte enables. The state also drives flat output vectors that a downstream arbiter reads.

Enable and pending each have two address windows. One sets bits where a 1 is written and the other clears them. Both windows read back the same live state, so a read-modify-write is never needed. A type register gives the number of implemented words. Enable bits that do not exist read back as zero, so software can write all ones and read back to find the real line count. Hardware interrupt inputs set pending bits. Each line is either edge-triggered, where a rising edge latches pending, or level-triggered, where pending is re-set on every cycle the line is high. Lines 0 to 15 are reserved for software-generated interrupts and can never become pending through this block.

Top module: `irq_dist_regbank`

## Requirements
- R1: After reset every enable, pending, group, group-modifier, priority and target bit is 0, both control enables are 0, and `rdata_o` is 0.
- R2: Writing to the set-enable word at byte address 0x100+4w sets enable bit 32w+k for each written 1 and leaves the others unchanged. The clear-enable word at 0x180+4w clears bits the same way. Both words read back the current enable state.
- R3: The set-pending word (0x200+4w) and the clear-pending word (0x280+4w) behave like the enable pair, but pending bits of lines 0 to 15 are never set.
- R4: The group word (0x080+4w) and the group-modifier word (0xD00+4w) are plain read/write words with one bit per line.
- R5: The priority of line n is byte n of the region at 0x400. The target mask of line n is byte n of the region at 0x800, which is byte lane n mod 4 of word 0x800+4*(n/4). Each lane is written only when its byte enable is set.
- R6: The type register at 0x004 reads NUM_WORDS-1 in bits [4:0] and 0 in all other bits.
- R7: The identification register at 0xFE8 reads ARCH_REV in bits [7:4] and 0 in all other bits. Writes to it have no effect.
- R8: In the control register at 0x000, bit 0 is the group 0 enable and bit 1 is the group 1 enable. Both are written when byte enable 0 is set. All other bits read 0.
- R9: Words and byte fields beyond the implemented lines read 0 and ignore writes. Writing all ones to every set-enable word reads back 1 only for lines below 32*NUM_WORDS.
- R10: For lines 16 and above, `irq_i` sets pending. When `trig_edge_i` is 1 the line is edge-triggered and a 0-to-1 change sets pending once. When `trig_edge_i` is 0 the line is level-triggered and pending is set on every cycle the input is high. A hardware set wins over a clear written in the same cycle.
- R11: A read presented with `req_i`=1 and `we_i`=0 appears on `rdata_o` on the next clock edge, and `rdata_o` holds its value between reads. In the single-bit windows, bits in byte lanes whose byte enable is 0 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address (byte address bits [11:2]) |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| rdata_o | output | 32 | Read data, registered |
| irq_i | input | 32*NUM_WORDS | Hardware interrupt inputs |
| trig_edge_i | input | 32*NUM_WORDS | Per-line trigger mode: 1 = edge, 0 = level |
| enable_o | output | 32*NUM_WORDS | Enable bit per line |
| pending_o | output | 32*NUM_WORDS | Pending bit per line |
| group_o | output | 32*NUM_WORDS | Group bit per line |
| gmod_o | output | 32*NUM_WORDS | Group-modifier bit per line |
| prio_o | output | 256*NUM_WORDS | Priority byte per line, line n in bits [8n+7:8n] |
| target_o | output | 256*NUM_WORDS | CPU target mask per line, line n in bits [8n+7:8n] |
| grp0_en_o | output | 1 | Group 0 enable |
| grp1_en_o | output | 1 | Group 1 enable |

## Verification
The hardest case to reach is a software clear and a hardware set landing on the same pending bit in the same cycle. The bench creates it by holding a level-triggered line high, writing its clear-pending bit, and then reading the pending bit back: it must still read 1. The edge-triggered case is handled the other way: the line is held high through the clear and must stay cleared until the input falls and rises again. The reserved low lines are checked with a one-hot sweep of set-pending writes and by driving one of their hardware inputs high; none of these may change the pending word.

// File: rtl/dist_pkg.sv
package dist_pkg;
  localparam int WORD_LINES = 32;

  // bit-window codes: byte address bits [11:7]
  localparam logic [4:0] WIN_GROUP    = 5'h01;
  localparam logic [4:0] WIN_SET_EN   = 5'h02;
  localparam logic [4:0] WIN_CLR_EN   = 5'h03;
  localparam logic [4:0] WIN_SET_PEND = 5'h04;
  localparam logic [4:0] WIN_CLR_PEND = 5'h05;
  localparam logic [4:0] WIN_GMOD     = 5'h1A;

  // byte-field regions: byte address bits [11:10]
  localparam logic [1:0] BLK_PRIO   = 2'b01;
  localparam logic [1:0] BLK_TARGET = 2'b10;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_TYPE  = 12'h004;
  localparam logic [11:0] OFS_IDENT = 12'hFE8;

  typedef struct packed {
    logic grp_wr;
    logic en_set;
    logic en_clr;
    logic pend_set;
    logic pend_clr;
    logic gmod_wr;
  } bit_wr_t;

  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/dist_trig.sv
module dist_trig #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] edge_i,
  output logic [NUM_LINES-1:0] hw_set_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  // level lines set while high, edge lines only on 0->1
  assign hw_set_o = irq_i & (~edge_i | ~prev_q);
endmodule

// File: rtl/dist_bit_word.sv
module dist_bit_word
  import dist_pkg::*;
#(
  parameter bit SGI_WORD = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  bit_wr_t     wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] bmask_i,
  input  logic [31:0] hw_set_i,
  output logic [31:0] en_o,
  output logic [31:0] pend_o,
  output logic [31:0] grp_o,
  output logic [31:0] gmod_o
);
  localparam logic [31:0] PEND_OK = SGI_WORD ? 32'hFFFF_0000 : 32'hFFFF_FFFF;

  logic [31:0] ones, en_set, en_clr, pd_set, pd_clr;

  assign ones   = wdata_i & bmask_i;
  assign en_set = wr_i.en_set   ? ones : '0;
  assign en_clr = wr_i.en_clr   ? ones : '0;
  assign pd_clr = wr_i.pend_clr ? ones : '0;
  assign pd_set = ((wr_i.pend_set ? ones : '0) | hw_set_i) & PEND_OK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pend_o <= '0;
      grp_o  <= '0;
      gmod_o <= '0;
    end else begin
      en_o   <= (en_o & ~en_clr) | en_set;
      pend_o <= (pend_o & ~pd_clr) | pd_set;  // set wins
      if (wr_i.grp_wr)  grp_o  <= (grp_o  & ~bmask_i) | ones;
      if (wr_i.gmod_wr) gmod_o <= (gmod_o & ~bmask_i) | ones;
    end
  end
endmodule

// File: rtl/dist_byte_word.sv
module dist_byte_word (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (we_i) begin
      for (int l = 0; l < 4; l++) begin
        if (be_i[l]) q_o[8*l +: 8] <= wdata_i[8*l +: 8];
      end
    end
  end
endmodule

// File: rtl/irq_dist_regbank.sv
module irq_dist_regbank
  import dist_pkg::*;
#(
  parameter int         NUM_WORDS = 2,
  parameter logic [3:0] ARCH_REV  = 4'h2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [11:2]                   addr_i,
  input  logic [31:0]                   wdata_i,
  input  logic [3:0]                    be_i,
  output logic [31:0]                   rdata_o,
  input  logic [NUM_WORDS*32-1:0]       irq_i,
  input  logic [NUM_WORDS*32-1:0]       trig_edge_i,
  output logic [NUM_WORDS*32-1:0]       enable_o,
  output logic [NUM_WORDS*32-1:0]       pending_o,
  output logic [NUM_WORDS*32-1:0]       group_o,
  output logic [NUM_WORDS*32-1:0]       gmod_o,
  output logic [NUM_WORDS*256-1:0]      prio_o,
  output logic [NUM_WORDS*256-1:0]      target_o,
  output logic                          grp0_en_o,
  output logic                          grp1_en_o
);
  localparam int NUM_LINES = NUM_WORDS * WORD_LINES;
  localparam int NUM_BYTE_WORDS = NUM_LINES / 4;

  logic [11:0] addr_w;
  logic [4:0]  win, widx;
  logic [7:0]  bidx;
  logic [1:0]  blk;
  logic        wr_en;
  logic [31:0] bmask;
  logic [31:0] rd_data;
  logic [1:0]  ctrl_q;
  logic [NUM_LINES-1:0] hw_set;

  logic [31:0] en_w   [NUM_WORDS];
  logic [31:0] pend_w [NUM_WORDS];
  logic [31:0] grp_w  [NUM_WORDS];
  logic [31:0] gmod_w [NUM_WORDS];
  logic [31:0] prio_w [NUM_BYTE_WORDS];
  logic [31:0] tgt_w  [NUM_BYTE_WORDS];

  assign addr_w = {addr_i, 2'b00};
  assign win    = addr_w[11:7];
  assign widx   = addr_w[6:2];
  assign bidx   = addr_w[9:2];
  assign blk    = addr_w[11:10];
  assign wr_en  = req_i & we_i;
  assign bmask  = be_to_mask(be_i);

  dist_trig #(.NUM_LINES(NUM_LINES)) trig_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .edge_i   (trig_edge_i),
    .hw_set_o (hw_set)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bits
    logic    hit;
    bit_wr_t wr_s;
    assign hit  = wr_en && (widx == 5'(w));
    assign wr_s = '{grp_wr:   hit && (win == WIN_GROUP),
                    en_set:   hit && (win == WIN_SET_EN),
                    en_clr:   hit && (win == WIN_CLR_EN),
                    pend_set: hit && (win == WIN_SET_PEND),
                    pend_clr: hit && (win == WIN_CLR_PEND),
                    gmod_wr:  hit && (win == WIN_GMOD)};

    dist_bit_word #(.SGI_WORD(w == 0)) word_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_s),
      .wdata_i  (wdata_i),
      .bmask_i  (bmask),
      .hw_set_i (hw_set[32*w +: 32]),
      .en_o     (en_w[w]),
      .pend_o   (pend_w[w]),
      .grp_o    (grp_w[w]),
      .gmod_o   (gmod_w[w])
    );

    assign enable_o [32*w +: 32] = en_w[w];
    assign pending_o[32*w +: 32] = pend_w[w];
    assign group_o  [32*w +: 32] = grp_w[w];
    assign gmod_o   [32*w +: 32] = gmod_w[w];
  end

  for (genvar b = 0; b < NUM_BYTE_WORDS; b++) begin : g_bytes
    logic sel;
    assign sel = wr_en && (bidx == 8'(b));

    dist_byte_word prio_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (sel && (blk == BLK_PRIO)),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .q_o     (prio_w[b])
    );

    dist_byte_word tgt_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (sel && (blk == BLK_TARGET)),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .q_o     (tgt_w[b])
    );

    assign prio_o  [32*b +: 32] = prio_w[b];
    assign target_o[32*b +: 32] = tgt_w[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctrl_q <= '0;
    else if (wr_en && addr_w == OFS_CTRL && be_i[0]) ctrl_q <= wdata_i[1:0];
  end

  assign grp0_en_o = ctrl_q[0];
  assign grp1_en_o = ctrl_q[1];

  always_comb begin
    rd_data = '0;
    if (addr_w == OFS_CTRL) begin
      rd_data = {30'b0, ctrl_q};
    end else if (addr_w == OFS_TYPE) begin
      rd_data = {27'b0, 5'(NUM_WORDS - 1)};
    end else if (addr_w == OFS_IDENT) begin
      rd_data = {24'b0, ARCH_REV, 4'b0};
    end else if (blk == BLK_PRIO) begin
      for (int b = 0; b < NUM_BYTE_WORDS; b++)
        if (bidx == 8'(b)) rd_data = prio_w[b];
    end else if (blk == BLK_TARGET) begin
      for (int b = 0; b < NUM_BYTE_WORDS; b++)
        if (bidx == 8'(b)) rd_data = tgt_w[b];
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (widx == 5'(w)) begin
          case (win)
            WIN_GROUP:                 rd_data = grp_w[w];
            WIN_SET_EN, WIN_CLR_EN:     rd_data = en_w[w];
            WIN_SET_PEND, WIN_CLR_PEND: rd_data = pend_w[w];
            WIN_GMOD:                  rd_data = gmod_w[w];
            default:                   rd_data = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_data;
  end
endmodule

// File: rtl/dist_regbank_chk.sv
module dist_regbank_chk #(
  parameter int NUM_WORDS = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [11:2]             addr_i,
  input logic [31:0]             wdata_i,
  input logic [3:0]              be_i,
  input logic [31:0]             rdata_o,
  input logic [NUM_WORDS*32-1:0] irq_i,
  input logic [NUM_WORDS*32-1:0] trig_edge_i,
  input logic [NUM_WORDS*32-1:0] enable_o,
  input logic [NUM_WORDS*32-1:0] pending_o,
  input logic                    grp0_en_o
);
  localparam int LAST = NUM_WORDS * 32 - 1;

  logic [11:0] a;
  logic [31:0] m;
  logic        rd, wr;
  assign a  = {addr_i, 2'b00};
  assign m  = {{8{be_i[3]}}, {8{be_i[2]}}, {8{be_i[1]}}, {8{be_i[0]}}} & wdata_i;
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  p_set_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && a == 12'h100) |=> ((enable_o[31:0] & $past(m)) == $past(m)));

  p_clr_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && a == 12'h180) |=> ((enable_o[31:0] & $past(m)) == 32'h0));

  p_sgi_no_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o[15:0] == 16'h0);

  p_type_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a == 12'h004) |=> (rdata_o == 32'(NUM_WORDS - 1)));

  p_ctrl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && a == 12'h000 && be_i[0]) |=> (grp0_en_o == $past(wdata_i[0])));

  p_unimpl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a[11:7] == 5'h02 && {27'b0, a[6:2]} >= 32'(NUM_WORDS)) |=> (rdata_o == 32'h0));

  p_edge_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_i[LAST]) && trig_edge_i[LAST]) |=> pending_o[LAST]);

  p_level_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i[LAST] && !trig_edge_i[LAST]) |=> pending_o[LAST]);

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind irq_dist_regbank dist_regbank_chk #(.NUM_WORDS(NUM_WORDS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .be_i        (be_i),
  .rdata_o     (rdata_o),
  .irq_i       (irq_i),
  .trig_edge_i (trig_edge_i),
  .enable_o    (enable_o),
  .pending_o   (pending_o),
  .grp0_en_o   (grp0_en_o)
);

// File: tb/irq_dist_regbank_tb_top.sv
`timescale 1ns/1ps
module irq_dist_regbank_tb_top;
  localparam int NW = 2;
  localparam int NL = NW * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:2] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic [NL-1:0] irq = '0, trig = '0;
  logic [NL-1:0] en_o, pend_o, grp_o, gmod_o;
  logic [NL*8-1:0] prio_o, tgt_o;
  logic g0, g1;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [NL-1:0] m_en = '0, m_pend = '0, m_grp = '0, m_gmod = '0;
  logic [7:0] m_prio [NL];
  logic [7:0] m_tgt  [NL];

  always #2.5 clk = ~clk;

  irq_dist_regbank #(.NUM_WORDS(NW), .ARCH_REV(4'h2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .irq_i(irq),
    .trig_edge_i(trig), .enable_o(en_o), .pending_o(pend_o),
    .group_o(grp_o), .gmod_o(gmod_o), .prio_o(prio_o), .target_o(tgt_o),
    .grp0_en_o(g0), .grp1_en_o(g1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a[11:2]; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a[11:2];
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] pack_bytes(input logic [7:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < NL; n++) begin m_prio[n] = '0; m_tgt[n] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 enable_o", en_o[31:0] | en_o[63:32], 32'h0);
    chk("R1 pending_o", pend_o[31:0] | pend_o[63:32], 32'h0);
    chk("R1 ctrl outs", {30'b0, g1, g0}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    for (int w = 0; w < NW; w++) begin
      rd(12'h080 + 12'(4*w), d); chk("R1 group", d, 32'h0);
      rd(12'h100 + 12'(4*w), d); chk("R1 enable", d, 32'h0);
      rd(12'h200 + 12'(4*w), d); chk("R1 pending", d, 32'h0);
      rd(12'hD00 + 12'(4*w), d); chk("R1 gmod", d, 32'h0);
    end
    rd(12'h400, d); chk("R1 prio", d, 32'h0);
    rd(12'h800, d); chk("R1 target", d, 32'h0);

    // R2 set-enable sweep, one line at a time
    for (int i = 0; i < NL; i++) begin
      logic [11:0] wa;
      wa = 12'h100 + 12'(4*(i/32));
      wr(wa, 32'h1 << (i % 32), 4'hF);
      m_en[i] = 1'b1;
      rd(wa, d); chk("R2 set window", d, m_en[32*(i/32) +: 32]);
      rd(wa + 12'h080, d); chk("R2 clear window read", d, m_en[32*(i/32) +: 32]);
    end
    wr(12'h180, 32'h5555_AAAA, 4'hF); m_en[31:0]  &= ~32'h5555_AAAA;
    wr(12'h184, 32'hF0F0_0F0F, 4'hF); m_en[63:32] &= ~32'hF0F0_0F0F;
    rd(12'h100, d); chk("R2 after clear w0", d, m_en[31:0]);
    rd(12'h184, d); chk("R2 after clear w1", d, m_en[63:32]);
    chk("R2 enable_o w0", en_o[31:0], m_en[31:0]);
    chk("R2 enable_o w1", en_o[63:32], m_en[63:32]);

    // R3 set-pending sweep on word 0; lines 0-15 must stay clear
    for (int i = 0; i < 32; i++) begin
      wr(12'h200, 32'h1 << i, 4'hF);
      if (i >= 16) m_pend[i] = 1'b1;
      rd(12'h280, d); chk("R3 pending sweep", d, m_pend[31:0]);
    end
    wr(12'h204, 32'h8000_0001, 4'hF); m_pend[63:32] |= 32'h8000_0001;
    wr(12'h280, 32'h00F0_F00F, 4'hF); m_pend[31:0]  &= ~32'h00F0_F00F;
    rd(12'h200, d); chk("R3 clear pending w0", d, m_pend[31:0]);
    rd(12'h284, d); chk("R3 pending w1", d, m_pend[63:32]);
    chk("R3 pending_o", pend_o[31:0], m_pend[31:0]);

    // R4 group and group-modifier
    wr(12'h080, 32'hA5A5_0FF0, 4'hF); m_grp[31:0]   = 32'hA5A5_0FF0;
    wr(12'h084, 32'h1234_5678, 4'hF); m_grp[63:32]  = 32'h1234_5678;
    wr(12'hD00, 32'h0F0F_C3C3, 4'hF); m_gmod[31:0]  = 32'h0F0F_C3C3;
    wr(12'hD04, 32'h8765_4321, 4'hF); m_gmod[63:32] = 32'h8765_4321;
    rd(12'h080, d); chk("R4 group w0", d, m_grp[31:0]);
    rd(12'h084, d); chk("R4 group w1", d, m_grp[63:32]);
    rd(12'hD00, d); chk("R4 gmod w0", d, m_gmod[31:0]);
    rd(12'hD04, d); chk("R4 gmod w1", d, m_gmod[63:32]);
    chk("R4 group_o", grp_o[63:32], m_grp[63:32]);
    chk("R4 gmod_o", gmod_o[31:0], m_gmod[31:0]);

    // R11 byte enables mask bit windows
    wr(12'h084, 32'hFFFF_FFFF, 4'b0010); m_grp[47:40] = 8'hFF;
    rd(12'h084, d); chk("R11 group byte lane", d, m_grp[63:32]);
    wr(12'h104, 32'hFFFF_FFFF, 4'b1000); m_en[63:56] = 8'hFF;
    rd(12'h104, d); chk("R11 enable byte lane", d, m_en[63:32]);

    // R5 priority and target, single-byte writes
    for (int n = 0; n < NL; n++) begin
      m_prio[n] = 8'((n * 37 + 11) % 256);
      m_tgt[n]  = 8'((n * 13 + 1) % 256);
      wr(12'h400 + 12'(4*(n/4)), 32'(m_prio[n]) << (8*(n%4)), 4'(1 << (n%4)));
      wr(12'h800 + 12'(4*(n/4)), 32'(m_tgt[n])  << (8*(n%4)), 4'(1 << (n%4)));
    end
    for (int b = 0; b < NL/4; b++) begin
      rd(12'h400 + 12'(4*b), d);
      chk("R5 prio word", d, pack_bytes(m_prio[4*b], m_prio[4*b+1], m_prio[4*b+2], m_prio[4*b+3]));
      rd(12'h800 + 12'(4*b), d);
      chk("R5 target word", d, pack_bytes(m_tgt[4*b], m_tgt[4*b+1], m_tgt[4*b+2], m_tgt[4*b+3]));
    end
    for (int n = 0; n < NL; n++) begin
      chk("R5 prio_o", {24'b0, prio_o[8*n +: 8]}, {24'b0, m_prio[n]});
      chk("R5 target_o", {24'b0, tgt_o[8*n +: 8]}, {24'b0, m_tgt[n]});
    end

    // R6 R7 type and identification
    rd(12'h004, d); chk("R6 type", d, 32'(NW - 1));
    wr(12'hFE8, 32'hFFFF_FFFF, 4'hF);
    rd(12'hFE8, d); chk("R7 ident", d, 32'h0000_0020);

    // R8 control
    wr(12'h000, 32'hFFFF_FFFF, 4'hF);
    rd(12'h000, d); chk("R8 ctrl all ones", d, 32'h3);
    chk("R8 ctrl outs", {30'b0, g1, g0}, 32'h3);
    wr(12'h000, 32'h0000_0002, 4'b1110);
    rd(12'h000, d); chk("R8 ctrl no lane0", d, 32'h3);
    wr(12'h000, 32'h0000_0002, 4'h1);
    rd(12'h000, d); chk("R8 ctrl grp1 only", d, 32'h2);

    // R9 unimplemented space
    for (int w = 0; w < 4; w++) begin
      wr(12'h100 + 12'(4*w), 32'hFFFF_FFFF, 4'hF);
      if (w < NW) m_en[32*w +: 32] = '1;
    end
    for (int w = 0; w < 4; w++) begin
      rd(12'h100 + 12'(4*w), d);
      chk("R9 enable discovery", d, (w < NW) ? 32'hFFFF_FFFF : 32'h0);
    end
    wr(12'h088, 32'hFFFF_FFFF, 4'hF);
    rd(12'h088, d); chk("R9 group unimpl", d, 32'h0);
    wr(12'h400 + 12'(NL), 32'hFFFF_FFFF, 4'hF);
    rd(12'h400 + 12'(NL), d); chk("R9 prio unimpl", d, 32'h0);
    chk("R9 prio_o intact", {24'b0, prio_o[8*(NL-1) +: 8]}, {24'b0, m_prio[NL-1]});
    rd(12'hD08, d); chk("R9 gmod unimpl", d, 32'h0);

    // R10 hardware sources
    wr(12'h280, 32'hFFFF_FFFF, 4'hF);
    wr(12'h284, 32'hFFFF_FFFF, 4'hF);
    m_pend = '0;
    @(negedge clk); trig[40] = 1'b1; irq[40] = 1'b1;
    @(negedge clk);
    chk("R10 edge sets pending", {31'b0, pend_o[40]}, 32'h1);
    wr(12'h284, 32'h0000_0100, 4'hF);
    rd(12'h204, d); chk("R10 edge held high stays clear", d, 32'h0);
    irq[40] = 1'b0;
    @(negedge clk); irq[40] = 1'b1;
    @(negedge clk);
    rd(12'h204, d); chk("R10 second edge", d, 32'h0000_0100);
    wr(12'h284, 32'h0000_0100, 4'hF);
    @(negedge clk); irq[41] = 1'b1;
    @(negedge clk);
    wr(12'h284, 32'h0000_0200, 4'hF);
    rd(12'h204, d); chk("R10 level survives clear", d, 32'h0000_0200);
    irq[41] = 1'b0;
    wr(12'h284, 32'h0000_0200, 4'hF);
    rd(12'h204, d); chk("R10 level released clears", d, 32'h0);
    irq[5] = 1'b1; trig[6] = 1'b1; irq[6] = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h200, d); chk("R10 low lines ignore irq", d, 32'h0);
    irq = '0;

    // R11 rdata holds between reads
    rd(12'h004, d);
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", rdata, 32'(NW - 1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule